// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block produces the digital waveform sequence for caption data that rides on one active line in each video field. The video timing logic gives it the current line number, a flag that tells it which field is running, and a horizontal sample counter at the pixel clock. From these it decides, sample by sample, which level a later DAC-stage mixer must output. Four levels are possible: blanking, one of the two phases of the run-in sine, a data one and a data zero.

A caption line is laid out as a fixed sequence of slots of equal length. The window opens a fixed number of samples after the line's sync reference. Seven run-in cycles come first. Three start bits follow, and then sixteen data bits. The data bits form two characters, each seven bits sent LSB first and followed by an odd parity bit that the block computes itself.

Two enables act independently, one for each caption line: line 21 in the first field and line 284 in the second. The 32-bit caption word is split between them. Bits 0 to 15 feed line 21 and bits 16 to 31 feed line 284. The word is copied into a shadow register on a field-start pulse, so a write from the processor part-way through a caption line does not disturb it. A one-cycle completion pulse follows the last sample of each caption line that was sent.

Top module: `cc_line_encoder`

## Requirements
- R1: After reset, and until the first caption window is reached, `level_code` is 0 (blank) and `line_sent` is 0.
- R2: Caption insertion happens only on line 21 with `field_second`=0 and `cc_en_a`=1, or on line 284 with `field_second`=1 and `cc_en_b`=1. On any other line, field or enable combination, `level_code` stays 0 (blank) for every sample.
- R3: Slot k covers the samples RUNIN_START + k·BIT_SAMPLES up to RUNIN_START + (k+1)·BIT_SAMPLES − 1. On a caption line, slots 0 to 6 are run-in. In each of these slots the first BIT_SAMPLES/2 samples give code 1 (positive phase) and the rest give code 2 (negative phase).
- R4: Slots 7 and 8 give code 3 (data zero) and slot 9 gives code 4 (data one), forming the start pattern.
- R5: Slots 10 to 25 carry data bits in this order: caption bits b..b+6, a parity bit, caption bits b+8..b+14, a parity bit. Here b is 0 on line 21 and 16 on line 284. A one gives code 4 and a zero gives code 3.
- R6: Each parity bit makes the count of ones in its character plus parity odd. The stored word bits 7, 15, 23 and 31 are ignored.
- R7: Samples before RUNIN_START, and samples at or after RUNIN_START + 26·BIT_SAMPLES, give code 0 even on a caption line.
- R8: `cap_data` is captured only in a cycle where `field_start` is 1. Changes to it at any other time have no effect on the bits sent.
- R9: `line_sent` is 1 for exactly one cycle, in the cycle after the last sample of slot 25 is presented on an enabled caption line.
- R10: `level_code` is registered. The code for a set of inputs appears in the cycle after the clock edge that samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | 10 | Current line number in the frame |
| field_second | input | 1 | 1 while the second field is running |
| hcount | input | 11 | Horizontal sample counter, 0 at the sync reference |
| cc_en_a | input | 1 | Enables captions on line 21 |
| cc_en_b | input | 1 | Enables captions on line 284 |
| cap_data | input | 32 | Caption word written by the processor |
| field_start | input | 1 | One-cycle pulse at field start; loads the shadow copy |
| level_code | output | 3 | 0 blank, 1 run-in positive, 2 run-in negative, 3 data zero, 4 data one |
| line_sent | output | 1 | One-cycle pulse after a caption line ends |

## Verification
Every output of this block comes from a register one edge behind its inputs. The level code and the completion pulse for a given line, field and sample count are therefore due one clock after that edge. A shadow load takes effect on the first sample presented after the edge that saw `field_start`. The bench drives inputs at a falling edge and reads the outputs at the next falling edge, which is exactly one rising edge later. For the completion pulse it sweeps the counter continuously across the end of the window and requires the pulse at precisely one sample. Expected codes come from a model in the bench built from the slot layout and the parity rule.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;
  typedef enum logic [2:0] {
    LVL_BLANK    = 3'd0,
    LVL_RUNIN_UP = 3'd1,
    LVL_RUNIN_DN = 3'd2,
    LVL_DATA_LO  = 3'd3,
    LVL_DATA_HI  = 3'd4
  } cc_level_e;

  localparam int RUNIN_SLOTS = 7;
  localparam int START_SLOTS = 3;
  localparam int DATA_SLOTS  = 16;
  localparam int TOTAL_SLOTS = RUNIN_SLOTS + START_SLOTS + DATA_SLOTS;
  localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
  localparam int WORD_W      = 2 * DATA_SLOTS;
endpackage

// File: rtl/cc_line_match.sv
module cc_line_match #(
  parameter int LINE_W = 10,
  parameter int LINE_A = 21,
  parameter int LINE_B = 284
) (
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_second,
  input  logic              en_a,
  input  logic              en_b,
  output logic              hit,
  output logic              use_upper
);
  localparam logic [LINE_W-1:0] LINE_A_C = LINE_W'(LINE_A);
  localparam logic [LINE_W-1:0] LINE_B_C = LINE_W'(LINE_B);

  logic match_a;
  logic match_b;

  always_comb begin
    match_a   = en_a && (line_num == LINE_A_C) && !field_second;
    match_b   = en_b && (line_num == LINE_B_C) && field_second;
    hit       = match_a || match_b;
    use_upper = match_b;
  end
endmodule

// File: rtl/cc_shadow_reg.sv
module cc_shadow_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] shadow_d;

  always_comb begin
    shadow_d = shadow_q;
    if (load) shadow_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  assign dout = shadow_q;

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(shadow_q));
endmodule

// File: rtl/cc_slot_timer.sv
module cc_slot_timer
  import cc_enc_pkg::*;
#(
  parameter int HCNT_W      = 11,
  parameter int BIT_SAMPLES = 54,
  parameter int RUNIN_START = 284
) (
  input  logic [HCNT_W-1:0] hcount,
  output logic              in_win,
  output logic              in_runin,
  output logic [SLOT_W-1:0] slot,
  output logic              first_half,
  output logic              last_sample
);
  localparam logic [HCNT_W-1:0] START_C = HCNT_W'(RUNIN_START);
  localparam logic [HCNT_W-1:0] BIT_C   = HCNT_W'(BIT_SAMPLES);
  localparam logic [HCNT_W-1:0] HALF_C  = HCNT_W'(BIT_SAMPLES / 2);
  localparam logic [HCNT_W-1:0] TOT_C   = HCNT_W'(TOTAL_SLOTS);
  localparam logic [HCNT_W-1:0] RUN_C   = HCNT_W'(RUNIN_SLOTS);

  logic [HCNT_W-1:0] offset;
  logic [HCNT_W-1:0] quo;
  logic [HCNT_W-1:0] rem;

  always_comb begin
    offset      = hcount - START_C;
    quo         = offset / BIT_C;
    rem         = offset % BIT_C;
    in_win      = (hcount >= START_C) && (quo < TOT_C);
    in_runin    = in_win && (quo < RUN_C);
    slot        = quo[SLOT_W-1:0];
    first_half  = rem < HALF_C;
    last_sample = in_win && (quo == TOT_C - 1'b1) && (rem == BIT_C - 1'b1);
  end
endmodule

// File: rtl/cc_bit_serializer.sv
module cc_bit_serializer
  import cc_enc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              use_upper,
  input  logic [SLOT_W-1:0] slot,
  input  logic              first_half,
  output cc_level_e         level
);
  logic [6:0]             char_lo;
  logic [6:0]             char_hi;
  logic [DATA_SLOTS-1:0]  payload;
  logic [TOTAL_SLOTS-1:0] frame;

  always_comb begin
    char_lo = use_upper ? word[22:16] : word[6:0];
    char_hi = use_upper ? word[30:24] : word[14:8];
    payload = {~^char_hi, char_hi, ~^char_lo, char_lo};
    frame   = {payload, 1'b1, 2'b00, {RUNIN_SLOTS{1'b0}}};
    if (slot < SLOT_W'(RUNIN_SLOTS))
      level = first_half ? LVL_RUNIN_UP : LVL_RUNIN_DN;
    else
      level = frame[slot] ? LVL_DATA_HI : LVL_DATA_LO;
  end
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
  import cc_enc_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int HCNT_W      = 11,
  parameter int BIT_SAMPLES = 54,
  parameter int RUNIN_START = 284,
  parameter int LINE_A      = 21,
  parameter int LINE_B      = 284
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_second,
  input  logic [HCNT_W-1:0] hcount,
  input  logic              cc_en_a,
  input  logic              cc_en_b,
  input  logic [31:0]       cap_data,
  input  logic              field_start,
  output logic [2:0]        level_code,
  output logic              line_sent
);
  logic              hit;
  logic              use_upper;
  logic [WORD_W-1:0] word;
  logic              in_win;
  logic              in_runin;
  logic [SLOT_W-1:0] slot;
  logic              first_half;
  logic              last_sample;
  cc_level_e         ser_level;
  cc_level_e         level_d;
  cc_level_e         level_q;
  logic              sent_d;
  logic              sent_q;

  cc_line_match #(.LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)) match_i (
    .line_num(line_num), .field_second(field_second),
    .en_a(cc_en_a), .en_b(cc_en_b), .hit(hit), .use_upper(use_upper));

  cc_shadow_reg #(.DATA_W(WORD_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .load(field_start), .din(cap_data), .dout(word));

  cc_slot_timer #(.HCNT_W(HCNT_W), .BIT_SAMPLES(BIT_SAMPLES),
                  .RUNIN_START(RUNIN_START)) timer_i (
    .hcount(hcount), .in_win(in_win), .in_runin(in_runin), .slot(slot),
    .first_half(first_half), .last_sample(last_sample));

  cc_bit_serializer ser_i (
    .word(word), .use_upper(use_upper), .slot(slot),
    .first_half(first_half), .level(ser_level));

  always_comb begin
    level_d = LVL_BLANK;
    if (hit && in_win) level_d = ser_level;
    sent_d = hit && last_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_BLANK;
      sent_q  <= 1'b0;
    end else begin
      level_q <= level_d;
      sent_q  <= sent_d;
    end
  end

  assign level_code = level_q;
  assign line_sent  = sent_q;

  assert_blank_off_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hit) |-> level_q == LVL_BLANK);
  assert_runin_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == LVL_RUNIN_UP || level_q == LVL_RUNIN_DN) |-> $past(in_runin));
  assert_blank_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_win) |-> level_q == LVL_BLANK);
  assert_sent_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q |-> $past(hit && last_sample));
  assert_sent_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q |=> !sent_q);
endmodule

// File: tb/cc_line_encoder_tb.sv
module cc_line_encoder_tb_top;
  localparam int BS = 54;
  localparam int RS = 284;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  line_num;
  logic        field_second;
  logic [10:0] hcount;
  logic        cc_en_a;
  logic        cc_en_b;
  logic [31:0] cap_data;
  logic        field_start;
  logic [2:0]  level_code;
  logic        line_sent;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cc_line_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_second(field_second),
    .hcount(hcount), .cc_en_a(cc_en_a), .cc_en_b(cc_en_b), .cap_data(cap_data),
    .field_start(field_start), .level_code(level_code), .line_sent(line_sent));

  function automatic logic [2:0] model(input logic upper, input logic [31:0] w,
                                       input int h);
    int off, slot, rem, k, base;
    logic [6:0] ch;
    if (h < RS || h >= RS + 26 * BS) return 3'd0;
    off  = h - RS;
    slot = off / BS;
    rem  = off % BS;
    if (slot < 7) return (rem < BS / 2) ? 3'd1 : 3'd2;
    if (slot < 9) return 3'd3;
    if (slot == 9) return 3'd4;
    base = upper ? 16 : 0;
    k    = slot - 10;
    ch   = (k < 8) ? w[base +: 7] : w[base + 8 +: 7];
    if (k == 7 || k == 15) return ($countones(ch) % 2 == 0) ? 3'd4 : 3'd3;
    return w[base + k] ? 3'd4 : 3'd3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic probe(input int ln, input logic fld, input int h,
                       input int exp, input string req);
    @(negedge clk);
    line_num = 10'(ln); field_second = fld; hcount = 11'(h);
    @(negedge clk);
    check(req, int'(level_code), exp);
  endtask

  task automatic load_word(input logic [31:0] w);
    @(negedge clk);
    cap_data = w; field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 level", int'(level_code), 0);
    check("R1 sent", int'(line_sent), 0);
  endtask

  task automatic t_runin;
    cc_en_a = 1'b1; cc_en_b = 1'b0;
    probe(21, 1'b0, RS, 1, "R3 first sample");
    probe(21, 1'b0, RS + BS / 2 - 1, 1, "R3 last positive");
    probe(21, 1'b0, RS + BS / 2, 2, "R3 first negative");
    probe(21, 1'b0, RS + BS - 1, 2, "R3 slot end");
    probe(21, 1'b0, RS + 6 * BS + 3, 1, "R3 slot 6");
  endtask

  task automatic t_start_bits;
    probe(21, 1'b0, RS + 7 * BS, 3, "R4 start 0a");
    probe(21, 1'b0, RS + 8 * BS + 20, 3, "R4 start 0b");
    probe(21, 1'b0, RS + 9 * BS + 53, 4, "R4 start 1");
  endtask

  task automatic t_data(input logic upper, input logic [31:0] w, input string req);
    int ln;
    ln = upper ? 284 : 21;
    cc_en_a = !upper; cc_en_b = upper;
    load_word(w);
    for (int s = 10; s < 26; s++) begin
      int h;
      h = RS + s * BS + BS / 2;
      probe(ln, upper, h, int'(model(upper, w, h)), req);
    end
  endtask

  task automatic t_parity_override;
    cc_en_a = 1'b1; cc_en_b = 1'b0;
    load_word(32'h0000_8080);
    probe(21, 1'b0, RS + 17 * BS + 5, 4, "R6 parity zero char");
    probe(21, 1'b0, RS + 25 * BS + 5, 4, "R6 parity zero char hi");
    load_word(32'h0000_0101);
    probe(21, 1'b0, RS + 17 * BS + 5, 3, "R6 parity one bit");
  endtask

  task automatic t_select;
    cc_en_a = 1'b0; cc_en_b = 1'b1;
    probe(21, 1'b0, RS + 3, 0, "R2 line 21 disabled");
    cc_en_a = 1'b1; cc_en_b = 1'b0;
    probe(284, 1'b1, RS + 3, 0, "R2 line 284 disabled");
    probe(21, 1'b1, RS + 3, 0, "R2 wrong field");
    probe(22, 1'b0, RS + 3, 0, "R2 other line");
    cc_en_a = 1'b1; cc_en_b = 1'b1;
    probe(21, 1'b0, RS + 3, 1, "R2 both enabled a");
    probe(284, 1'b1, RS + 9 * BS, 4, "R2 both enabled b");
  endtask

  task automatic t_window;
    cc_en_a = 1'b1;
    probe(21, 1'b0, RS - 1, 0, "R7 before window");
    probe(21, 1'b0, 0, 0, "R7 at sync");
    probe(21, 1'b0, RS + 26 * BS, 0, "R7 after window");
    probe(21, 1'b0, RS + 26 * BS + 100, 0, "R7 late");
  endtask

  task automatic t_shadow;
    logic [31:0] oldw;
    cc_en_a = 1'b1; cc_en_b = 1'b0;
    oldw = 32'h0000_2A55;
    load_word(oldw);
    @(negedge clk);
    cap_data = ~oldw;
    for (int s = 10; s < 26; s += 3) begin
      int h;
      h = RS + s * BS + 7;
      probe(21, 1'b0, h, int'(model(1'b0, oldw, h)), "R8 write ignored");
    end
    load_word(~oldw);
    probe(21, 1'b0, RS + 10 * BS, int'(model(1'b0, ~oldw, RS + 10 * BS)), "R8 new load");
  endtask

  task automatic t_sent;
    int pulses, at;
    cc_en_a = 1'b1; cc_en_b = 1'b0;
    pulses = 0; at = -1;
    @(negedge clk);
    line_num = 10'd21; field_second = 1'b0;
    for (int h = RS + 26 * BS - 4; h < RS + 26 * BS + 4; h++) begin
      hcount = 11'(h);
      @(negedge clk);
      if (line_sent) begin pulses++; at = h; end
    end
    check("R9 pulse count", pulses, 1);
    check("R9 pulse sample", at, RS + 26 * BS - 1);
    check("R10 level after window", int'(level_code), 0);
    cc_en_a = 1'b0;
    pulses = 0;
    for (int h = RS + 26 * BS - 2; h < RS + 26 * BS + 2; h++) begin
      hcount = 11'(h);
      @(negedge clk);
      if (line_sent) pulses++;
    end
    check("R9 no pulse when disabled", pulses, 0);
  endtask

  initial begin
    rst_n = 1'b0; line_num = '0; field_second = 1'b0; hcount = '0;
    cc_en_a = 1'b0; cc_en_b = 1'b0; cap_data = '0; field_start = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_runin;
    t_start_bits;
    t_data(1'b0, 32'h5AC3_A53C, "R5 line 21");
    t_data(1'b1, 32'h5AC3_A53C, "R5 line 284");
    t_data(1'b0, 32'hFFFF_7F01, "R10 line 21 pattern");
    t_parity_override;
    t_select;
    t_window;
    t_shadow;
    t_sent;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule